// File: doc/BRIEF.md
# Dual-Port Burst-Addressed Synchronous RAM

This block is a two-port static RAM. Its left and right ports are fully independent, and each one can read or write any word in the same cycle as the other. Each port registers its controls, address and write data on the rising clock edge. One clock edge later the port performs its access against a shared array.

Each port has a burst address generator. A port can take its address from the pins, restart at word zero, step to the next word, or stay on the word it used last. This lets a master stream a block of words after giving only the first address. A restart costs no idle cycle, because the access made in the restart cycle goes to word zero. A build-time parameter chooses how reads are returned:

- **Flow-through:** read data comes straight from the array read register.
- **Pipelined:** read data passes through one more output register.

Output enable, chip select and the direction of the cycle decide whether a port presents data. A valid flag stands in for driving the data bus. Two byte lanes split each word for writes.

Top module: `dpram_burst`

## Requirements
- R1: Both ports can access any word in the same cycle without waiting for each other, and a word written through one port is returned by a later read through the other port.
- R2: A read captured at clock edge N presents its data after edge N+1 when PIPELINED=0, and after edge N+2 when PIPELINED=1.
- R3: The burst counter resolves its controls in a fixed priority: clear, then load, then step, then hold. A clear sends the access of that same cycle to word 0.
- R4: When the load strobe is captured and clear is not, the access goes to the captured pin address, and the counter then holds that address.
- R5: With step enabled and no load or clear, the access address is one more than the previous access address of that port. It wraps from the top word to word 0.
- R6: In a write, the low lane enable covers bits [DW/2-1:0] and the high lane enable covers bits [DW-1:DW/2]. A lane whose enable is low keeps its stored value.
- R7: A cycle captured with chip select low writes nothing and returns no read data. The burst counter still follows that cycle's counter controls.
- R8: When both ports write the same word in one cycle, the left port's data is stored in every lane the left port enables. The right port's data is stored only in lanes the left port leaves alone.
- R9: A read on one port of a word that the other port writes in the same cycle returns the value held before that write.
- R10: The valid flag is low whenever output enable is low at the output. It is also low for a cycle captured as a write. The read data bus is all zeros whenever the valid flag is low.
- R11: A synchronous active-high reset clears both valid flags, zeroes the read data and sets both counters to 0. A holding access after reset therefore reads word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left chip select |
| l_we | input | 1 | Left write (1) or read (0) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left high byte-lane enable |
| l_lb | input | 1 | Left low byte-lane enable |
| l_ld | input | 1 | Left address load strobe |
| l_cnt_en | input | 1 | Left counter step enable |
| l_cnt_clr | input | 1 | Left counter clear to word 0 |
| l_addr | input | AW | Left external address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| r_cs | input | 1 | Right chip select |
| r_we | input | 1 | Right write (1) or read (0) |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right high byte-lane enable |
| r_lb | input | 1 | Right low byte-lane enable |
| r_ld | input | 1 | Right address load strobe |
| r_cnt_en | input | 1 | Right counter step enable |
| r_cnt_clr | input | 1 | Right counter clear to word 0 |
| r_addr | input | AW | Right external address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench targets the cases where each failure would show at the outputs:

- **Read latency:** two copies of the block, one per read mode, run on the same stimulus. A register too many or too few in either mode would shift every read by one cycle.
- **Counter edge cases:** the counter is driven with clear, load and step all at once, with a load at the top word followed by steps, and with a hold right after reset. A wrong priority would read the pin address instead of word 0. A missing wrap would fall outside the array. A counter left uncleared by reset would read a stale word.
- **Collisions:** same-word writes from both ports, partial-lane overlaps and cross-port read-during-write are all exercised. A port order reversed in the array would store right-port data. A read taken after the write would return the new value instead of the old one.
- **Output gating:** chip-select-low writes, output enable dropped on a read, and write cycles check that nothing leaks onto the data bus.

// File: rtl/dpb_pkg.sv
`timescale 1ns/1ps
package dpb_pkg;

    localparam int NUM_PORTS = 2;
    localparam int LANES     = 2;
    localparam int LEFT      = 0;
    localparam int RIGHT     = 1;

    // Counter operation, in decreasing priority: ZERO, LOAD, STEP, HOLD
    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_STEP = 2'd1,
        CTR_LOAD = 2'd2,
        CTR_ZERO = 2'd3
    } ctr_op_e;

    // Per-port control bundle captured at the clock edge
    typedef struct packed {
        logic cs;
        logic we;
        logic ub;
        logic lb;
        logic ld;
        logic en;
        logic clr;
    } port_ctl_t;

    function automatic ctr_op_e ctr_decode(input port_ctl_t c);
        if (c.clr)
            return CTR_ZERO;
        else if (c.ld)
            return CTR_LOAD;
        else if (c.en)
            return CTR_STEP;
        else
            return CTR_HOLD;
    endfunction

    // Lane 0 is the low half of the word, lane 1 the high half
    function automatic logic [LANES-1:0] lane_mask(input port_ctl_t c);
        return {c.ub, c.lb};
    endfunction

endpackage

// File: rtl/dpb_burst_ctr.sv
`timescale 1ns/1ps
module dpb_burst_ctr
    import dpb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctr_op_e       op,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cur_addr
);

    // Address used by the most recent access of this port
    logic [AW-1:0] last_q;

    always_comb begin
        unique case (op)
            CTR_ZERO: cur_addr = '0;
            CTR_LOAD: cur_addr = ext_addr;
            CTR_STEP: cur_addr = last_q + AW'(1);
            default:  cur_addr = last_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else
            last_q <= cur_addr;
    end

endmodule

// File: rtl/dpb_port_front.sv
`timescale 1ns/1ps
module dpb_port_front
    import dpb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  port_ctl_t        ctl_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [AW-1:0]    acc_addr,
    output logic             acc_wr,
    output logic             acc_rd,
    output logic [LANES-1:0] acc_be,
    output logic [DW-1:0]    acc_wdata
);

    port_ctl_t     ctl_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    ctr_op_e       op;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctl_q   <= ctl_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    assign op = ctr_decode(ctl_q);

    dpb_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ext_addr (addr_q),
        .cur_addr (acc_addr)
    );

    assign acc_wr    = ctl_q.cs & ctl_q.we;
    assign acc_rd    = ctl_q.cs & ~ctl_q.we;
    assign acc_be    = lane_mask(ctl_q);
    assign acc_wdata = wdata_q;

endmodule

// File: rtl/dpb_mem_core.sv
`timescale 1ns/1ps
module dpb_mem_core
    import dpb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PORTS-1:0]                wr,
    input  logic [NUM_PORTS-1:0]                rd,
    input  logic [NUM_PORTS-1:0][LANES-1:0]     be,
    input  logic [NUM_PORTS-1:0][AW-1:0]        addr,
    input  logic [NUM_PORTS-1:0][DW-1:0]        wdata,
    output logic [NUM_PORTS-1:0][DW-1:0]        rdq,
    output logic [NUM_PORTS-1:0]                rvld
);

    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / LANES;

    logic [DW-1:0] mem [DEPTH];

    // Right port is applied first so the left port's lanes land last
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr[p] && be[p][b])
                    mem[addr[p]][b*LW +: LW] <= wdata[p][b*LW +: LW];
            end
        end
    end

    // Reads sample the array before this edge's writes take effect
    always_ff @(posedge clk) begin
        if (rst) begin
            rdq  <= '0;
            rvld <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rvld[p] <= rd[p];
                if (rd[p])
                    rdq[p] <= mem[addr[p]];
            end
        end
    end

endmodule

// File: rtl/dpb_out_stage.sv
`timescale 1ns/1ps
module dpb_out_stage #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] d_i,
    input  logic          v_i,
    output logic [DW-1:0] d_o,
    output logic          v_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            d_o <= '0;
            v_o <= 1'b0;
        end else begin
            d_o <= d_i;
            v_o <= v_i;
        end
    end

endmodule

// File: rtl/dpram_burst.sv
`timescale 1ns/1ps
module dpram_burst
    import dpb_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 18,
    parameter bit PIPELINED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_cs,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic          l_ub,
    input  logic          l_lb,
    input  logic          l_ld,
    input  logic          l_cnt_en,
    input  logic          l_cnt_clr,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rvalid,
    input  logic          r_cs,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic          r_ub,
    input  logic          r_lb,
    input  logic          r_ld,
    input  logic          r_cnt_en,
    input  logic          r_cnt_clr,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rvalid
);

    port_ctl_t [NUM_PORTS-1:0]            ctl;
    logic [NUM_PORTS-1:0][AW-1:0]         ext_addr;
    logic [NUM_PORTS-1:0][DW-1:0]         ext_wdata;
    logic [NUM_PORTS-1:0]                 oe;

    logic [NUM_PORTS-1:0][AW-1:0]         acc_addr;
    logic [NUM_PORTS-1:0]                 acc_wr;
    logic [NUM_PORTS-1:0]                 acc_rd;
    logic [NUM_PORTS-1:0][LANES-1:0]      acc_be;
    logic [NUM_PORTS-1:0][DW-1:0]         acc_wdata;

    logic [NUM_PORTS-1:0][DW-1:0]         arr_q;
    logic [NUM_PORTS-1:0]                 arr_v;
    logic [NUM_PORTS-1:0][DW-1:0]         out_d;
    logic [NUM_PORTS-1:0]                 out_v;
    logic [NUM_PORTS-1:0][DW-1:0]         pin_d;
    logic [NUM_PORTS-1:0]                 pin_v;

    assign ctl[LEFT]  = '{cs: l_cs, we: l_we, ub: l_ub, lb: l_lb,
                          ld: l_ld, en: l_cnt_en, clr: l_cnt_clr};
    assign ctl[RIGHT] = '{cs: r_cs, we: r_we, ub: r_ub, lb: r_lb,
                          ld: r_ld, en: r_cnt_en, clr: r_cnt_clr};
    assign ext_addr   = {r_addr, l_addr};
    assign ext_wdata  = {r_wdata, l_wdata};
    assign oe         = {r_oe, l_oe};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpb_port_front #(.AW(AW), .DW(DW)) u_front (
            .clk       (clk),
            .rst       (rst),
            .ctl_i     (ctl[p]),
            .addr_i    (ext_addr[p]),
            .wdata_i   (ext_wdata[p]),
            .acc_addr  (acc_addr[p]),
            .acc_wr    (acc_wr[p]),
            .acc_rd    (acc_rd[p]),
            .acc_be    (acc_be[p]),
            .acc_wdata (acc_wdata[p])
        );

        if (PIPELINED) begin : g_pipe
            dpb_out_stage #(.DW(DW)) u_out (
                .clk (clk),
                .rst (rst),
                .d_i (arr_q[p]),
                .v_i (arr_v[p]),
                .d_o (out_d[p]),
                .v_o (out_v[p])
            );
        end else begin : g_flow
            assign out_d[p] = arr_q[p];
            assign out_v[p] = arr_v[p];
        end

        assign pin_v[p] = out_v[p] & oe[p];
        assign pin_d[p] = pin_v[p] ? out_d[p] : '0;
    end

    dpb_mem_core #(.AW(AW), .DW(DW)) u_core (
        .clk   (clk),
        .rst   (rst),
        .wr    (acc_wr),
        .rd    (acc_rd),
        .be    (acc_be),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .rdq   (arr_q),
        .rvld  (arr_v)
    );

    assign l_rdata  = pin_d[LEFT];
    assign l_rvalid = pin_v[LEFT];
    assign r_rdata  = pin_d[RIGHT];
    assign r_rvalid = pin_v[RIGHT];

endmodule

// File: rtl/dpram_burst_chk.sv
`timescale 1ns/1ps
module dpram_burst_chk #(
    parameter int AW        = 8,
    parameter int DW        = 18,
    parameter bit PIPELINED = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                l_cs,
    input logic                l_we,
    input logic                l_oe,
    input logic                l_ld,
    input logic                l_cnt_en,
    input logic                l_cnt_clr,
    input logic [AW-1:0]       l_addr,
    input logic [DW-1:0]       l_rdata,
    input logic                l_rvalid,
    input logic                r_oe,
    input logic [DW-1:0]       r_rdata,
    input logic                r_rvalid,
    input logic [1:0][AW-1:0]  acc_addr
);

    // R10: valid only while output enable is high, bus quiet otherwise
    a_r10_left_needs_oe: assert property (@(posedge clk) disable iff (rst)
        l_rvalid |-> l_oe);
    a_r10_right_needs_oe: assert property (@(posedge clk) disable iff (rst)
        r_rvalid |-> r_oe);
    a_r10_left_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !l_rvalid |-> (l_rdata == '0));
    a_r10_right_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !r_rvalid |-> (r_rdata == '0));

    // R3: a captured clear sends the access to word 0
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(l_cnt_clr)) |-> (acc_addr[0] == '0));

    // R4: a captured load without clear uses the pin address
    a_r4_load_pins: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(l_ld && !l_cnt_clr)) |-> (acc_addr[0] == $past(l_addr)));

    // R5: a captured step advances by one from the previous access, wrapping
    a_r5_step_wraps: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && $past(l_cnt_en && !l_ld && !l_cnt_clr))
        |-> (acc_addr[0] == AW'($past(acc_addr[0]) + AW'(1))));

    if (PIPELINED) begin : g_pipe_chk
        // R2: read captured three samples ago is visible when oe is high
        a_r2_pipe_latency: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(!rst, 2) && $past(!rst, 3)
             && $past(l_cs && !l_we, 3) && l_oe) |-> l_rvalid);
        // R7: no data for a deselected or write cycle
        a_r7_pipe_no_read: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst, 3) && $past(!l_cs || l_we, 3)) |-> !l_rvalid);
    end else begin : g_flow_chk
        a_r2_flow_latency: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(!rst, 2)
             && $past(l_cs && !l_we, 2) && l_oe) |-> l_rvalid);
        a_r7_flow_no_read: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst, 2) && $past(!l_cs || l_we, 2)) |-> !l_rvalid);
    end

endmodule

bind dpram_burst dpram_burst_chk #(
    .AW(AW), .DW(DW), .PIPELINED(PIPELINED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .l_cs      (l_cs),
    .l_we      (l_we),
    .l_oe      (l_oe),
    .l_ld      (l_ld),
    .l_cnt_en  (l_cnt_en),
    .l_cnt_clr (l_cnt_clr),
    .l_addr    (l_addr),
    .l_rdata   (l_rdata),
    .l_rvalid  (l_rvalid),
    .r_oe      (r_oe),
    .r_rdata   (r_rdata),
    .r_rvalid  (r_rvalid),
    .acc_addr  (acc_addr)
);

// File: tb/dpram_burst_bench.sv
`timescale 1ns/1ps
module dpram_burst_bench;
    import dpb_pkg::*;

    localparam int AW    = 8;
    localparam int DW    = 18;
    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    // Signals currently on the pins, and the values for the next step
    logic          drv_rst;
    port_ctl_t     drv_ctl [2];
    logic [AW-1:0] drv_addr[2];
    logic [DW-1:0] drv_wd  [2];
    logic          drv_oe  [2];
    logic          nx_rst;
    port_ctl_t     nx_ctl  [2];
    logic [AW-1:0] nx_addr [2];
    logic [DW-1:0] nx_wd   [2];
    logic          nx_oe   [2];

    logic [DW-1:0] p_rd[2], f_rd[2];
    logic          p_v[2],  f_v[2];

    dpram_burst #(.AW(AW), .DW(DW), .PIPELINED(1'b1)) u_dpram_burst (
        .clk(clk), .rst(drv_rst),
        .l_cs(drv_ctl[0].cs), .l_we(drv_ctl[0].we), .l_oe(drv_oe[0]),
        .l_ub(drv_ctl[0].ub), .l_lb(drv_ctl[0].lb), .l_ld(drv_ctl[0].ld),
        .l_cnt_en(drv_ctl[0].en), .l_cnt_clr(drv_ctl[0].clr),
        .l_addr(drv_addr[0]), .l_wdata(drv_wd[0]), .l_rdata(p_rd[0]), .l_rvalid(p_v[0]),
        .r_cs(drv_ctl[1].cs), .r_we(drv_ctl[1].we), .r_oe(drv_oe[1]),
        .r_ub(drv_ctl[1].ub), .r_lb(drv_ctl[1].lb), .r_ld(drv_ctl[1].ld),
        .r_cnt_en(drv_ctl[1].en), .r_cnt_clr(drv_ctl[1].clr),
        .r_addr(drv_addr[1]), .r_wdata(drv_wd[1]), .r_rdata(p_rd[1]), .r_rvalid(p_v[1])
    );

    dpram_burst #(.AW(AW), .DW(DW), .PIPELINED(1'b0)) u_dpram_burst_ft (
        .clk(clk), .rst(drv_rst),
        .l_cs(drv_ctl[0].cs), .l_we(drv_ctl[0].we), .l_oe(drv_oe[0]),
        .l_ub(drv_ctl[0].ub), .l_lb(drv_ctl[0].lb), .l_ld(drv_ctl[0].ld),
        .l_cnt_en(drv_ctl[0].en), .l_cnt_clr(drv_ctl[0].clr),
        .l_addr(drv_addr[0]), .l_wdata(drv_wd[0]), .l_rdata(f_rd[0]), .l_rvalid(f_v[0]),
        .r_cs(drv_ctl[1].cs), .r_we(drv_ctl[1].we), .r_oe(drv_oe[1]),
        .r_ub(drv_ctl[1].ub), .r_lb(drv_ctl[1].lb), .r_ld(drv_ctl[1].ld),
        .r_cnt_en(drv_ctl[1].en), .r_cnt_clr(drv_ctl[1].clr),
        .r_addr(drv_addr[1]), .r_wdata(drv_wd[1]), .r_rdata(f_rd[1]), .r_rvalid(f_v[1])
    );

    // Reference model
    logic [DW-1:0] mref [DEPTH];
    logic [AW-1:0] mctr [2];
    logic          hv [2][4];
    logic [DW-1:0] hd [2][4];
    string         ht [2][4];
    string         tag;
    int            n_checks = 0;
    int            n_fail   = 0;

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 2731 + 17);
    endfunction

    task automatic check_out(input int p, input string mode, input logic v, input logic [DW-1:0] d,
                             input logic ev, input logic [DW-1:0] ed, input string t, input logic oe);
        logic          xv;
        logic [DW-1:0] xd;
        xv = ev & oe;
        xd = xv ? ed : '0;
        n_checks++;
        if (v !== xv || d !== xd) begin
            n_fail++;
            $display("FAIL %s port %0d %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     t, p, mode, v, d, xv, xd);
        end
    endtask

    task automatic model_cycle();
        logic [AW-1:0] ea [2];
        for (int p = 0; p < 2; p++) begin
            if (drv_rst) begin
                mctr[p] = '0;
                ea[p]   = '0;
                hv[p][0] = 1'b0;
            end else begin
                if (drv_ctl[p].clr)     ea[p] = '0;
                else if (drv_ctl[p].ld) ea[p] = drv_addr[p];
                else if (drv_ctl[p].en) ea[p] = mctr[p] + AW'(1);
                else                    ea[p] = mctr[p];
                mctr[p]  = ea[p];
                hv[p][0] = drv_ctl[p].cs & ~drv_ctl[p].we;
            end
            hd[p][0] = mref[ea[p]];
            ht[p][0] = tag;
        end
        for (int p = 1; p >= 0; p--) begin
            if (!drv_rst && drv_ctl[p].cs && drv_ctl[p].we) begin
                if (drv_ctl[p].lb) mref[ea[p]][LW-1:0]  = drv_wd[p][LW-1:0];
                if (drv_ctl[p].ub) mref[ea[p]][DW-1:LW] = drv_wd[p][DW-1:LW];
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            for (int k = 3; k > 0; k--) begin
                hv[p][k] = hv[p][k-1];
                hd[p][k] = hd[p][k-1];
                ht[p][k] = ht[p][k-1];
            end
            check_out(p, "flow", f_v[p], f_rd[p], hv[p][2], hd[p][2], ht[p][2], drv_oe[p]);
            check_out(p, "pipe", p_v[p], p_rd[p], hv[p][3], hd[p][3], ht[p][3], drv_oe[p]);
        end
        drv_rst = nx_rst;
        for (int p = 0; p < 2; p++) begin
            drv_ctl[p]  = nx_ctl[p];
            drv_addr[p] = nx_addr[p];
            drv_wd[p]   = nx_wd[p];
            drv_oe[p]   = nx_oe[p];
        end
        model_cycle();
    endtask

    task automatic idle(input int p);
        nx_ctl[p]  = '0;
        nx_addr[p] = '0;
        nx_wd[p]   = '0;
        nx_oe[p]   = 1'b1;
    endtask

    task automatic req(input int p, input logic cs, input logic we, input logic ub, input logic lb,
                       input logic ld, input logic en, input logic clr,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
        nx_ctl[p]  = '{cs: cs, we: we, ub: ub, lb: lb, ld: ld, en: en, clr: clr};
        nx_addr[p] = a;
        nx_wd[p]   = wd;
        nx_oe[p]   = 1'b1;
    endtask

    task automatic drain();
        idle(0);
        idle(1);
        repeat (4) step();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no completion, expected finish before timeout");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h00C0FFEE);
        drv_rst = 1'b1;
        nx_rst  = 1'b1;
        for (int p = 0; p < 2; p++) begin
            drv_ctl[p] = '0; drv_addr[p] = '0; drv_wd[p] = '0; drv_oe[p] = 1'b1;
            idle(p);
            mctr[p] = '0;
            for (int k = 0; k < 4; k++) begin
                hv[p][k] = 1'b0; hd[p][k] = '0; ht[p][k] = "R11";
            end
        end

        // R11: outputs quiet through reset
        tag = "R11";
        repeat (4) step();
        nx_rst = 1'b0;
        step();

        // R4: fill the array from the left port with a loaded burst
        tag = "R4";
        req(0, 1, 1, 1, 1, 1, 0, 0, '0, pat(0));
        step();
        for (int i = 1; i < DEPTH; i++) begin
            req(0, 1, 1, 1, 1, 0, 1, 0, '0, pat(i));
            step();
        end
        drain();

        // R1: right port streams back everything the left port wrote
        tag = "R1";
        req(1, 1, 0, 1, 1, 1, 0, 0, '0, '0);
        step();
        for (int i = 1; i < DEPTH; i++) begin
            req(1, 1, 0, 1, 1, 0, 1, 0, '0, '0);
            step();
        end
        drain();

        // R2: back-to-back bursts on both ports, compared in both read modes
        tag = "R2";
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(40), '0);
        req(1, 1, 0, 1, 1, 1, 0, 0, AW'(90), '0);
        step();
        for (int i = 0; i < 8; i++) begin
            req(0, 1, 0, 1, 1, 0, 1, 0, '0, '0);
            req(1, 1, 0, 1, 1, 0, 1, 0, '0, '0);
            step();
        end
        drain();

        // R3: clear beats load and step; then load, step, hold, clear alone
        tag = "R3";
        req(0, 1, 0, 1, 1, 1, 1, 1, AW'(50), '0); step();
        req(0, 1, 0, 1, 1, 1, 1, 0, AW'(50), '0); step();
        req(0, 1, 0, 1, 1, 0, 1, 0, AW'(77), '0); step();
        req(0, 1, 0, 1, 1, 0, 0, 0, AW'(77), '0); step();
        req(0, 1, 0, 1, 1, 0, 1, 1, AW'(77), '0); step();
        drain();

        // R5: step across the top word
        tag = "R5";
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(DEPTH - 2), '0); step();
        for (int i = 0; i < 3; i++) begin
            req(0, 1, 0, 1, 1, 0, 1, 0, '0, '0); step();
        end
        drain();

        // R6: single-lane writes keep the other lane
        tag = "R6";
        req(0, 1, 1, 0, 1, 1, 0, 0, AW'(10), '1); step();
        req(0, 1, 1, 1, 0, 1, 0, 0, AW'(11), '1); step();
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(10), '0); step();
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(11), '0); step();
        drain();

        // R7: deselected write leaves memory, deselected read stays quiet
        tag = "R7";
        req(0, 0, 1, 1, 1, 1, 0, 0, AW'(12), '1); step();
        req(0, 0, 0, 1, 1, 1, 0, 0, AW'(12), '0); step();
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(12), '0); step();
        drain();

        // R8: same-word writes, full and partial overlap
        tag = "R8";
        req(0, 1, 1, 1, 1, 1, 0, 0, AW'(20), DW'(18'h0AAAA));
        req(1, 1, 1, 1, 1, 1, 0, 0, AW'(20), DW'(18'h15555));
        step();
        req(0, 1, 1, 0, 1, 1, 0, 0, AW'(21), DW'(18'h01234));
        req(1, 1, 1, 1, 1, 1, 0, 0, AW'(21), DW'(18'h3FFFF));
        step();
        idle(1);
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(20), '0); step();
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(21), '0); step();
        drain();

        // R9: cross-port read during write sees old word, then the new one
        tag = "R9";
        req(0, 1, 1, 1, 1, 1, 0, 0, AW'(30), DW'(18'h2BEEF));
        req(1, 1, 0, 1, 1, 1, 0, 0, AW'(30), '0);
        step();
        idle(0);
        req(1, 1, 0, 1, 1, 0, 0, 0, '0, '0);
        step();
        drain();

        // R10: output enable low on a read, and a write cycle with oe high
        tag = "R10";
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(5), '0); nx_oe[0] = 1'b0; step();
        nx_oe[0] = 1'b0; step();
        nx_oe[0] = 1'b0; step();
        req(0, 1, 1, 1, 1, 1, 0, 0, AW'(6), pat(600)); step();
        req(0, 1, 0, 1, 1, 1, 0, 0, AW'(6), '0); step();
        drain();

        // R1: constrained random traffic on both ports
        tag = "R1";
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < 2; p++) begin
                r = $urandom;
                nx_ctl[p].cs  = (r[3:0] != 4'd0);
                nx_ctl[p].we  = r[4] & r[5];
                nx_ctl[p].ub  = r[6] | r[7];
                nx_ctl[p].lb  = r[8] | r[9];
                nx_ctl[p].ld  = r[10];
                nx_ctl[p].en  = r[11];
                nx_ctl[p].clr = (r[15:12] == 4'd0);
                nx_addr[p]    = r[16] ? AW'(r[19:17]) : AW'(r[31:24]);
                nx_wd[p]      = DW'($urandom);
                nx_oe[p]      = (r[23:21] != 3'd0);
            end
            step();
        end
        drain();

        // R11: second reset, then a holding read must return word 0
        tag = "R11";
        nx_rst = 1'b1;
        repeat (3) step();
        nx_rst = 1'b0;
        req(0, 1, 0, 1, 1, 0, 0, 0, AW'(99), '0);
        req(1, 1, 0, 1, 1, 0, 0, 0, AW'(42), '0);
        step();
        drain();

        summary();
        $finish;
    end

endmodule